// File: doc/BRIEF.md
# Dependence-Based Instruction Steering Logic

This block sits in a processor front end, after renaming. For each instruction it picks one in-order instruction buffer out of a pool of execution buffers. It keeps dependent work close to its producer. A consumer is placed directly behind the buffer of the instruction that produces its operand. If that is not possible, it goes to an idle buffer in the same group of buffers, called a cluster. If neither works, steering stalls. No global cost search takes place.

Three pieces of state drive the choice. The first is a table with one entry per architectural register. Each entry records the buffer that the register's pending producer was sent to, and whether some consumer has already been placed behind that producer. The other two are per-buffer vectors that record which buffers are idle and which are full, sampled from feedback sent by the execution units. The block handles one instruction per cycle.

Instructions arrive on a valid/ready stream, and the chosen buffer number leaves on a second valid/ready stream. `out_valid` rises as soon as a buffer has been found. It does not wait for `out_ready`. `ins_ready` is high only when a buffer has been found and `out_ready` is high. Upstream must hold the instruction stable while `ins_valid` is high and `ins_ready` is low. The table and the vectors change only on a transfer, which is a cycle with `ins_valid` and `ins_ready` both high. Writebacks and feedback are the exceptions: they update the state whether or not a transfer happens.

Top module: `dep_steer_unit`

## Requirements
- R1: After reset every table entry is invalid, every buffer counts as idle and none counts as full. The first instruction transferred after reset, whatever its sources, is sent to buffer 0. While `ins_valid` is low, `out_valid` and `stall` are low.
- R2: `out_valid` = `ins_valid` and a buffer was found. `stall` = `ins_valid` and no buffer was found. `ins_ready` = a buffer was found and `out_ready`. With `out_ready` low, nothing is transferred and no state other than writeback and feedback changes.
- R3: A source is outstanding when its enable is set and its table entry is valid. An instruction with no outstanding source goes to an idle buffer in the cluster that has the most idle buffers. A tie goes to the lower-numbered cluster. Within that cluster the lowest-numbered idle buffer is taken. If no buffer is idle, the instruction stalls.
- R4: With one outstanding source, the instruction goes to that producer's buffer if the producer's consumer bit is clear and that buffer is not marked full.
- R5: With one outstanding source, when R4 does not apply, the instruction goes to the lowest-numbered idle buffer in the producer's cluster. If that cluster has no idle buffer, the instruction stalls.
- R6: With two outstanding sources, the rule of R4 is tried first for source 1, then for source 2. If neither applies, the idle buffers of both producers' clusters are pooled and one is chosen as in R3. If the pool is empty, the instruction stalls.
- R7: On a transfer that places the instruction behind a producer, that source's consumer bit is set. On every transfer with `rd_en`, the entry for `rd_reg` becomes valid, holds the chosen buffer and has its consumer bit clear. This write also overrides a consumer bit set in the same cycle on the same entry.
- R8: `wb_valid` invalidates the entry for `wb_reg`, and this takes effect for the next decision. If a transfer writes the same register in the same cycle, the new producer's entry survives. A decision always reads the table as it stood before the current edge.
- R9: The idle and full vectors are loaded every cycle from `unit_empty` and `unit_full`, and each decision uses the values loaded at the previous edge. A buffer chosen on a transfer is treated as not idle for the next decision. A buffer never reports idle and full at the same time.
- R10: Buffer b belongs to cluster b / CLUSTER_SIZE. Clusters are groups of consecutive buffer numbers, and a cluster search never returns a buffer outside the clusters it is given.
- R11: A source whose enable is low is never outstanding, even if its table entry is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction present |
| ins_ready | output | 1 | Instruction accepted this cycle |
| rs1_en | input | 1 | First source register is read |
| rs1_reg | input | $clog2(NUM_REGS) | First source register |
| rs2_en | input | 1 | Second source register is read |
| rs2_reg | input | $clog2(NUM_REGS) | Second source register |
| rd_en | input | 1 | Instruction writes a register |
| rd_reg | input | $clog2(NUM_REGS) | Destination register |
| out_valid | output | 1 | Chosen buffer is valid |
| out_ready | input | 1 | Downstream takes the choice |
| out_buf | output | $clog2(NUM_BUFS) | Chosen buffer number |
| stall | output | 1 | Instruction present, no buffer qualifies |
| wb_valid | input | 1 | A register value was written back |
| wb_reg | input | $clog2(NUM_REGS) | Register written back |
| unit_empty | input | NUM_BUFS | Per-buffer idle feedback |
| unit_full | input | NUM_BUFS | Per-buffer full feedback |

## Verification
The hardest case to reach is the third step of the two-source rule. In that case both producers are still pending, each either already has a consumer behind it or sits in a full buffer, and the idle buffers are spread unevenly over the two producers' clusters. Directed sequences build this case on purpose. They first place consumers behind producers, then shape the idle vector over a quiet cycle, and finally issue the two-source instruction. Random stimulus draws registers from a small pool and biases the idle and full vectors, which makes collisions, exhausted clusters and same-cycle writebacks frequent.

// File: rtl/steer_pkg.sv
package steer_pkg;
  typedef enum logic [2:0] {
    SP_STALL   = 3'd0,
    SP_ANY     = 3'd1,
    SP_BEHIND1 = 3'd2,
    SP_BEHIND2 = 3'd3,
    SP_NEAR    = 3'd4
  } steer_path_e;
endpackage

// File: rtl/steer_pick.sv
module steer_pick #(
  parameter int NUM_BUFS     = 8,
  parameter int CLUSTER_SIZE = 4
) (
  input  logic [NUM_BUFS-1:0]         cand,
  output logic                        found,
  output logic [$clog2(NUM_BUFS)-1:0] idx
);
  localparam int NC = NUM_BUFS / CLUSTER_SIZE;
  localparam int BW = $clog2(NUM_BUFS);
  localparam int CW = $clog2(CLUSTER_SIZE + 1);

  logic [CW-1:0] cnt [NC];

  // idle count per cluster
  for (genvar c = 0; c < NC; c++) begin : g_cnt
    logic [CW-1:0] n;
    always_comb begin
      n = '0;
      for (int j = 0; j < CLUSTER_SIZE; j++) n = n + CW'(cand[c*CLUSTER_SIZE + j]);
    end
    assign cnt[c] = n;
  end

  // fullest cluster wins (strict compare keeps the lower cluster on ties),
  // then the lowest buffer inside it
  always_comb begin
    int best;
    logic [CW-1:0] best_n;
    best   = 0;
    best_n = '0;
    for (int c = 0; c < NC; c++) begin
      if (cnt[c] > best_n) begin
        best_n = cnt[c];
        best   = c;
      end
    end
    found = (best_n != '0);
    idx   = '0;
    for (int j = CLUSTER_SIZE - 1; j >= 0; j--) begin
      if (cand[best*CLUSTER_SIZE + j]) idx = BW'(best*CLUSTER_SIZE + j);
    end
  end
endmodule

// File: rtl/steer_lpt.sv
module steer_lpt #(
  parameter int NUM_REGS = 32,
  parameter int NUM_BUFS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(NUM_REGS)-1:0] rd_a,
  input  logic [$clog2(NUM_REGS)-1:0] rd_b,
  output logic                        a_vld,
  output logic [$clog2(NUM_BUFS)-1:0] a_bid,
  output logic                        a_cb,
  output logic                        b_vld,
  output logic [$clog2(NUM_BUFS)-1:0] b_bid,
  output logic                        b_cb,
  input  logic                        mark_en,
  input  logic [$clog2(NUM_REGS)-1:0] mark_reg,
  input  logic                        put_en,
  input  logic [$clog2(NUM_REGS)-1:0] put_reg,
  input  logic [$clog2(NUM_BUFS)-1:0] put_bid,
  input  logic                        clr_en,
  input  logic [$clog2(NUM_REGS)-1:0] clr_reg
);
  localparam int RW = $clog2(NUM_REGS);
  localparam int BW = $clog2(NUM_BUFS);

  logic [NUM_REGS-1:0] vld_v;
  logic [NUM_REGS-1:0] cb_v;
  logic [BW-1:0]       bid_a [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_ent
    logic          vld_q;
    logic          cb_q;
    logic [BW-1:0] bid_q;
    logic          hit_put, hit_clr, hit_mark;
    assign hit_put  = put_en  && (put_reg  == RW'(r));
    assign hit_clr  = clr_en  && (clr_reg  == RW'(r));
    assign hit_mark = mark_en && (mark_reg == RW'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        cb_q  <= 1'b0;
        bid_q <= '0;
      end else if (hit_put) begin
        vld_q <= 1'b1;
        cb_q  <= 1'b0;
        bid_q <= put_bid;
      end else begin
        if (hit_clr)  vld_q <= 1'b0;
        if (hit_mark) cb_q  <= 1'b1;
      end
    end
    assign vld_v[r] = vld_q;
    assign cb_v[r]  = cb_q;
    assign bid_a[r] = bid_q;
  end

  assign a_vld = vld_v[rd_a];
  assign a_bid = bid_a[rd_a];
  assign a_cb  = cb_v[rd_a];
  assign b_vld = vld_v[rd_b];
  assign b_bid = bid_a[rd_b];
  assign b_cb  = cb_v[rd_b];

  // R7: a recorded producer is valid, points at its buffer, has no consumer yet
  a_r7_dst_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    put_en |=> (vld_v[$past(put_reg)] && !cb_v[$past(put_reg)] &&
                bid_a[$past(put_reg)] == $past(put_bid)));

  // R8: writeback clears the entry unless a new producer claims it
  a_r8_wb_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(put_en && put_reg == clr_reg)) |=> !vld_v[$past(clr_reg)]);

  // R7: placing a consumer sets the bit unless the entry is rewritten
  a_r7_mark_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_en && !(put_en && put_reg == mark_reg)) |=> cb_v[$past(mark_reg)]);
endmodule

// File: rtl/steer_vec.sv
module steer_vec #(
  parameter int NUM_BUFS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BUFS-1:0]         empty_i,
  input  logic [NUM_BUFS-1:0]         full_i,
  input  logic                        take_en,
  input  logic [$clog2(NUM_BUFS)-1:0] take_idx,
  output logic [NUM_BUFS-1:0]         empty_q,
  output logic [NUM_BUFS-1:0]         full_q
);
  logic [NUM_BUFS-1:0] take_mask;

  always_comb begin
    take_mask = '0;
    if (take_en) take_mask[take_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= '1;
      full_q  <= '0;
    end else begin
      empty_q <= empty_i & ~take_mask;
      full_q  <= full_i;
    end
  end

  // R9: a buffer just chosen is never offered as idle to the next decision
  a_r9_taken_busy: assert property (@(posedge clk) disable iff (!rst_n)
    take_en |=> !empty_q[$past(take_idx)]);

  // R9: feedback arrives with one cycle of latency
  a_r9_full_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> full_q == $past(full_i));
endmodule

// File: rtl/dep_steer_unit.sv
module dep_steer_unit
  import steer_pkg::*;
#(
  parameter int NUM_REGS     = 32,
  parameter int NUM_BUFS     = 8,
  parameter int CLUSTER_SIZE = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ins_valid,
  output logic                        ins_ready,
  input  logic                        rs1_en,
  input  logic [$clog2(NUM_REGS)-1:0] rs1_reg,
  input  logic                        rs2_en,
  input  logic [$clog2(NUM_REGS)-1:0] rs2_reg,
  input  logic                        rd_en,
  input  logic [$clog2(NUM_REGS)-1:0] rd_reg,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [$clog2(NUM_BUFS)-1:0] out_buf,
  output logic                        stall,
  input  logic                        wb_valid,
  input  logic [$clog2(NUM_REGS)-1:0] wb_reg,
  input  logic [NUM_BUFS-1:0]         unit_empty,
  input  logic [NUM_BUFS-1:0]         unit_full
);
  localparam int RW = $clog2(NUM_REGS);
  localparam int BW = $clog2(NUM_BUFS);

  logic          p1_vld, p1_cb, p2_vld, p2_cb;
  logic [BW-1:0] p1_bid, p2_bid;
  logic [NUM_BUFS-1:0] empty_q, full_q;
  logic [NUM_BUFS-1:0] near1, near2, cand;
  logic          out1, out2, room1, room2;
  logic          pick_found;
  logic [BW-1:0] pick_idx;
  steer_path_e   pre_path, path;
  logic          fire, have;
  logic          mark_en;
  logic [RW-1:0] mark_reg;

  // cluster membership of each producer's buffer
  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_near
    assign near1[b] = (b / CLUSTER_SIZE) == (32'(p1_bid) / CLUSTER_SIZE);
    assign near2[b] = (b / CLUSTER_SIZE) == (32'(p2_bid) / CLUSTER_SIZE);
  end

  assign out1  = rs1_en && p1_vld;
  assign out2  = rs2_en && p2_vld;
  assign room1 = !p1_cb && !full_q[p1_bid];
  assign room2 = !p2_cb && !full_q[p2_bid];

  // rule selection: behind a producer, or a search over a candidate set
  always_comb begin
    pre_path = SP_STALL;
    cand     = '0;
    unique case ({out1, out2})
      2'b00: begin
        pre_path = SP_ANY;
        cand     = empty_q;
      end
      2'b10: begin
        if (room1) pre_path = SP_BEHIND1;
        else begin
          pre_path = SP_NEAR;
          cand     = empty_q & near1;
        end
      end
      2'b01: begin
        if (room2) pre_path = SP_BEHIND2;
        else begin
          pre_path = SP_NEAR;
          cand     = empty_q & near2;
        end
      end
      default: begin
        if (room1)      pre_path = SP_BEHIND1;
        else if (room2) pre_path = SP_BEHIND2;
        else begin
          pre_path = SP_NEAR;
          cand     = empty_q & (near1 | near2);
        end
      end
    endcase
  end

  steer_pick #(.NUM_BUFS(NUM_BUFS), .CLUSTER_SIZE(CLUSTER_SIZE)) u_pick (
    .cand  (cand),
    .found (pick_found),
    .idx   (pick_idx)
  );

  always_comb begin
    path    = pre_path;
    out_buf = pick_idx;
    unique case (pre_path)
      SP_BEHIND1: out_buf = p1_bid;
      SP_BEHIND2: out_buf = p2_bid;
      SP_ANY, SP_NEAR: if (!pick_found) path = SP_STALL;
      default: path = SP_STALL;
    endcase
  end

  assign have      = (path != SP_STALL);
  assign out_valid = ins_valid && have;
  assign ins_ready = have && out_ready;
  assign stall     = ins_valid && !have;
  assign fire      = ins_valid && ins_ready;
  assign mark_en   = fire && (path == SP_BEHIND1 || path == SP_BEHIND2);
  assign mark_reg  = (path == SP_BEHIND1) ? rs1_reg : rs2_reg;

  steer_lpt #(.NUM_REGS(NUM_REGS), .NUM_BUFS(NUM_BUFS)) u_lpt (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a     (rs1_reg),
    .rd_b     (rs2_reg),
    .a_vld    (p1_vld),
    .a_bid    (p1_bid),
    .a_cb     (p1_cb),
    .b_vld    (p2_vld),
    .b_bid    (p2_bid),
    .b_cb     (p2_cb),
    .mark_en  (mark_en),
    .mark_reg (mark_reg),
    .put_en   (fire && rd_en),
    .put_reg  (rd_reg),
    .put_bid  (out_buf),
    .clr_en   (wb_valid),
    .clr_reg  (wb_reg)
  );

  steer_vec #(.NUM_BUFS(NUM_BUFS)) u_vec (
    .clk      (clk),
    .rst_n    (rst_n),
    .empty_i  (unit_empty),
    .full_i   (unit_full),
    .take_en  (fire),
    .take_idx (out_buf),
    .empty_q  (empty_q),
    .full_q   (full_q)
  );

  // R2: a stalled instruction is neither offered nor accepted
  a_r2_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!ins_ready && !out_valid));

  // R3: with nothing outstanding the choice is an idle buffer
  a_r3_free_is_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out1 && !out2) |-> empty_q[out_buf]);

  // R4: never steered into a buffer that reported full
  a_r4_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !full_q[out_buf]);

  // R5: a fallback for one source stays in the producer's cluster
  a_r5_near_cluster: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out1 && !out2 && out_buf != p1_bid) |-> near1[out_buf]);

  // R6: a fallback for two sources stays in one of the two clusters
  a_r6_union_cluster: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out1 && out2 && out_buf != p1_bid && out_buf != p2_bid)
      |-> (near1[out_buf] || near2[out_buf]));
endmodule

// File: tb/test_dep_steer_unit.sv
`timescale 1ns/1ps
module test_dep_steer_unit;
  localparam int NR = 32;
  localparam int NB = 8;
  localparam int CS = 4;
  localparam int NC = NB / CS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ins_valid = 1'b0, ins_ready;
  logic rs1_en = 1'b0, rs2_en = 1'b0, rd_en = 1'b0;
  logic [4:0] rs1_reg = '0, rs2_reg = '0, rd_reg = '0, wb_reg = '0;
  logic out_valid, out_ready = 1'b1, stall, wb_valid = 1'b0;
  logic [2:0] out_buf;
  logic [NB-1:0] unit_empty = '1, unit_full = '0;

  int n_chk = 0, n_bad = 0;
  bit m_vld [NR];
  bit m_cb  [NR];
  int m_buf [NR];
  logic [NB-1:0] m_empty, m_full;

  always #2.5 clk = ~clk;

  dep_steer_unit i_dep_steer_unit (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .rs1_en(rs1_en), .rs1_reg(rs1_reg), .rs2_en(rs2_en), .rs2_reg(rs2_reg),
    .rd_en(rd_en), .rd_reg(rd_reg), .out_valid(out_valid), .out_ready(out_ready),
    .out_buf(out_buf), .stall(stall), .wb_valid(wb_valid), .wb_reg(wb_reg),
    .unit_empty(unit_empty), .unit_full(unit_full));

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [NB-1:0] cmask(input int b);
    logic [NB-1:0] m = '0;
    for (int i = 0; i < NB; i++) m[i] = (i / CS) == (b / CS);
    return m;
  endfunction

  function automatic int mpick(input logic [NB-1:0] m);
    int best = -1, bestn = 0;
    for (int c = 0; c < NC; c++) begin
      int n = 0;
      for (int j = 0; j < CS; j++) n += int'(m[c*CS + j]);
      if (n > bestn) begin bestn = n; best = c; end
    end
    if (best < 0) return -1;
    for (int j = 0; j < CS; j++) if (m[best*CS + j]) return best*CS + j;
    return -1;
  endfunction

  // compare this cycle against the model, then advance the model and the clock
  task automatic go(input string tag);
    int exp, side;
    bit o1, o2, ok1, ok2, fire;
    string t;
    #1;
    o1 = rs1_en && m_vld[rs1_reg];
    o2 = rs2_en && m_vld[rs2_reg];
    ok1 = o1 && !m_cb[rs1_reg] && !m_full[m_buf[rs1_reg]];
    ok2 = o2 && !m_cb[rs2_reg] && !m_full[m_buf[rs2_reg]];
    side = 0;
    if (!o1 && !o2) exp = mpick(m_empty);
    else if (o1 && o2) begin
      if (ok1) begin exp = m_buf[rs1_reg]; side = 1; end
      else if (ok2) begin exp = m_buf[rs2_reg]; side = 2; end
      else exp = mpick(m_empty & (cmask(m_buf[rs1_reg]) | cmask(m_buf[rs2_reg])));
    end else if (o1) begin
      if (ok1) begin exp = m_buf[rs1_reg]; side = 1; end
      else exp = mpick(m_empty & cmask(m_buf[rs1_reg]));
    end else begin
      if (ok2) begin exp = m_buf[rs2_reg]; side = 2; end
      else exp = mpick(m_empty & cmask(m_buf[rs2_reg]));
    end
    if (tag != "") t = tag;
    else if (!o1 && !o2) t = "R3";
    else if (o1 && o2) t = "R6";
    else t = (side != 0) ? "R4" : "R5";
    chk(out_valid == (ins_valid && exp >= 0), t, "out_valid", int'(out_valid), int'(ins_valid && exp >= 0));
    chk(stall == (ins_valid && exp < 0), "R2", "stall", int'(stall), int'(ins_valid && exp < 0));
    chk(ins_ready == (exp >= 0 && out_ready), "R2", "ins_ready", int'(ins_ready), int'(exp >= 0 && out_ready));
    if (ins_valid && exp >= 0) chk(int'(out_buf) == exp, t, "out_buf", int'(out_buf), exp);
    fire = ins_valid && exp >= 0 && out_ready;
    if (wb_valid) m_vld[wb_reg] = 1'b0;
    if (fire && side == 1) m_cb[rs1_reg] = 1'b1;
    if (fire && side == 2) m_cb[rs2_reg] = 1'b1;
    if (fire && rd_en) begin
      m_vld[rd_reg] = 1'b1; m_cb[rd_reg] = 1'b0; m_buf[rd_reg] = exp;
    end
    m_empty = unit_empty;
    if (fire) m_empty[exp] = 1'b0;
    m_full = unit_full;
    @(posedge clk);
    #1;
  endtask

  task automatic ins(input bit v, input bit e1, input int a, input bit e2, input int b,
                     input bit ed, input int d);
    ins_valid = v; rs1_en = e1; rs1_reg = 5'(a); rs2_en = e2; rs2_reg = 5'(b);
    rd_en = ed; rd_reg = 5'(d);
  endtask

  task automatic env(input bit ordy, input logic [NB-1:0] emp, input logic [NB-1:0] ful,
                     input bit wv, input int wr);
    out_ready = ordy; unit_empty = emp; unit_full = ful; wb_valid = wv; wb_reg = 5'(wr);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int seed;
    void'($urandom(32'h5EED_0042));
    for (int r = 0; r < NR; r++) begin m_vld[r] = 0; m_cb[r] = 0; m_buf[r] = 0; end
    m_empty = '1; m_full = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: idle after reset, then first transfer lands in buffer 0
    env(1, '1, '0, 0, 0);
    ins(0, 0, 0, 0, 0, 0, 0); go("R1");
    ins(1, 1, 9, 1, 10, 1, 1); go("R1");            // r1 -> buf0
    ins(1, 1, 1, 0, 0, 1, 2); go("R4");             // behind r1 in buf0
    ins(1, 1, 1, 0, 0, 1, 3); go("R5");             // r1 has consumer -> buf1
    ins(1, 1, 1, 1, 3, 1, 4); go("R6");             // falls to second producer
    ins(1, 1, 2, 1, 1, 1, 5); go("R6");             // first producer free
    ins(1, 1, 1, 1, 2, 1, 6); go("R6");             // both claimed -> pooled search
    // R5: producer cluster exhausted -> stall
    ins(0, 0, 0, 0, 0, 0, 0); env(1, 8'hF0, 8'h00, 0, 0); go("R9");
    ins(1, 1, 1, 0, 0, 1, 7); go("R5");
    // R9: full buffer blocks placement behind its producer
    ins(0, 0, 0, 0, 0, 0, 0); env(1, 8'hF0, 8'h02, 0, 0); go("R9");
    ins(1, 1, 4, 0, 0, 1, 8); go("R9");
    ins(0, 0, 0, 0, 0, 0, 0); env(1, 8'hFD, 8'h00, 0, 0); go("R9");
    ins(1, 1, 4, 0, 0, 1, 8); go("R4");
    // R8: writeback frees the operand; same-cycle rewrite survives
    ins(0, 0, 0, 0, 0, 0, 0); env(1, '1, '0, 1, 1); go("R8");
    env(1, '1, '0, 0, 0);
    ins(1, 1, 1, 0, 0, 1, 9); go("R8");
    env(1, '1, '0, 1, 10);
    ins(1, 0, 0, 0, 0, 1, 10); go("R8");
    env(1, '1, '0, 0, 0);
    ins(1, 1, 10, 0, 0, 1, 11); go("R8");
    // R11: disabled source is not a dependence
    ins(1, 0, 10, 0, 11, 1, 12); go("R11");
    // R7: destination equal to source rewrites the entry with a clear bit
    ins(1, 1, 12, 0, 0, 1, 12); go("R7");
    ins(1, 1, 12, 0, 0, 0, 0); go("R7");
    // R3: load balance by idle count per cluster
    ins(0, 0, 0, 0, 0, 0, 0); env(1, 8'h1F, 8'h00, 0, 0); go("R3");
    ins(1, 0, 0, 0, 0, 1, 13); go("R3");
    ins(0, 0, 0, 0, 0, 0, 0); env(1, 8'h71, 8'h00, 0, 0); go("R3");
    ins(1, 0, 0, 0, 0, 1, 13); go("R3");
    // R10: fallback stays in cluster 1 although buffer 0 is idle
    ins(1, 1, 13, 0, 0, 1, 14); go("R10");
    ins(1, 1, 13, 0, 0, 1, 15); go("R10");
    // R2: back-pressure holds everything
    env(0, 8'hF1, 8'h00, 0, 0);
    ins(1, 1, 13, 0, 0, 1, 16); go("R2");
    env(1, 8'hF1, 8'h00, 0, 0);
    ins(1, 1, 13, 0, 0, 1, 16); go("R2");

    // constrained random mix
    for (int cyc = 0; cyc < 4000; cyc++) begin
      logic [NB-1:0] e, f;
      if (!(ins_valid && !ins_ready)) begin
        ins(($urandom % 10) < 8, ($urandom % 10) < 7, $urandom % 8,
            ($urandom % 10) < 6, $urandom % 8, ($urandom % 10) < 8, $urandom % 8);
      end
      for (int b = 0; b < NB; b++) begin
        e[b] = ($urandom % 10) < 5;
        f[b] = !e[b] && (($urandom % 10) < 3);
      end
      env(($urandom % 10) < 8, e, f, ($urandom % 10) < 3, $urandom % 8);
      go("");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule